// File: doc/BRIEF.md
# Parallel Tag Match Unit

This unit holds the tags of a highly associative cache and finds a tag by its value, not by its position. A lookup key is formed from the tag and set-index bits of a CPU address. The unit compares that key against every stored entry in the same cycle. When a valid entry holds the key, the unit returns that entry's number. The cache then uses this number directly as the line position in its data array. When no valid entry holds the key, the unit reports a miss.

A single write port updates the store. Each write names one entry and either loads a new key into it, marking it valid, or invalidates it. The lookup result is registered, so it appears one clock after the key is presented. The data array, the replacement choice and the memory side of the cache sit outside this unit.

Top module: `tag_cam`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, every entry is invalid and `res_valid`, `res_hit` and `res_line` are all 0.
- R2: `res_valid` is high in the cycle after a cycle with `lk_valid` high, and low in the cycle after a cycle with `lk_valid` low.
- R3: A lookup whose key equals the key of a valid entry gives `res_hit` = 1 and `res_line` = that entry's number, counted from 0, one cycle later.
- R4: A lookup that matches no valid entry gives `res_hit` = 0 and `res_line` = 0.
- R5: An invalid entry never matches, even when the key it still holds equals the lookup key.
- R6: When several valid entries hold the lookup key, `res_line` is the lowest entry number among them.
- R7: A write with `wr_en` = 1 and `wr_valid` = 1 stores `wr_key` in entry `wr_addr` and marks it valid. A lookup presented in the next cycle sees the new entry.
- R8: A write with `wr_en` = 1 and `wr_valid` = 0 marks entry `wr_addr` invalid, so it no longer matches from the next cycle on.
- R9: A lookup presented in the same cycle as a write is compared against the contents from before that write.
- R10: `res_hit` is 0 whenever `res_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_valid | input | 1 | A lookup is presented this cycle |
| lk_key | input | KEY_W (26) | Tag plus set-index key to search for |
| wr_en | input | 1 | Write one entry this cycle |
| wr_addr | input | IDX_W (5) | Entry number to write |
| wr_key | input | KEY_W (26) | Key stored by the write |
| wr_valid | input | 1 | 1 loads the entry as valid, 0 invalidates it |
| res_valid | output | 1 | A lookup result is presented this cycle |
| res_hit | output | 1 | The lookup found a valid matching entry |
| res_line | output | IDX_W (5) | Number of the lowest matching entry, 0 on a miss |

## Verification
If a valid bit or stored key is wrong inside the store, the next lookup for that key reports the wrong result at the ports. It shows up one clock after the lookup is presented: either as a hit where a miss is expected or the reverse, or as a line number that points to a different entry. A fault in the priority choice only shows when two entries hold the same key, so the stimulus uses a narrow key range that makes such duplicates common. A lookup presented together with a write to the same entry catches logic that lets the write through too early.

// File: rtl/tag_cam.sv
`timescale 1ns/1ps
module tag_cam #(
  parameter int ENTRIES = 32,
  parameter int KEY_W   = 26,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [KEY_W-1:0] lk_key,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_addr,
  input  logic [KEY_W-1:0] wr_key,
  input  logic             wr_valid,
  output logic             res_valid,
  output logic             res_hit,
  output logic [IDX_W-1:0] res_line
);

  logic [ENTRIES-1:0] vld_q;
  logic [KEY_W-1:0]   key_q [ENTRIES];
  logic [ENTRIES-1:0] match;
  logic               any_match;
  logic [IDX_W-1:0]   first_idx;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign match[e] = vld_q[e] && (key_q[e] == lk_key);
  end

  assign any_match = |match;

  always_comb begin
    first_idx = '0;
    for (int e = ENTRIES - 1; e >= 0; e--)
      if (match[e]) first_idx = IDX_W'(e);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else if (wr_en) vld_q[wr_addr] <= wr_valid;
  end

  always_ff @(posedge clk) begin
    if (wr_en) key_q[wr_addr] <= wr_key;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_line  <= '0;
    end else begin
      res_valid <= lk_valid;
      res_hit   <= lk_valid && any_match;
      res_line  <= (lk_valid && any_match) ? first_idx : '0;
    end
  end

endmodule

// File: rtl/tag_cam_chk.sv
`timescale 1ns/1ps
module tag_cam_chk #(
  parameter int ENTRIES = 32,
  parameter int KEY_W   = 26,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_valid,
  input logic [KEY_W-1:0] lk_key,
  input logic             wr_en,
  input logic [IDX_W-1:0] wr_addr,
  input logic [KEY_W-1:0] wr_key,
  input logic             wr_valid,
  input logic             res_valid,
  input logic             res_hit,
  input logic [IDX_W-1:0] res_line
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!res_valid && !res_hit && res_line == '0));

  // R2
  result_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> res_valid);

  // R2
  no_spurious_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !res_valid);

  // R10
  hit_needs_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> !res_hit);

  // R4
  miss_line_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_hit) |-> res_line == '0);

  // R7
  load_then_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_valid ##1 lk_valid && lk_key == $past(wr_key))
      |=> (res_hit && res_line <= $past(wr_addr, 2)));

  // R8
  drop_then_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_valid ##1 lk_valid)
      |=> !(res_hit && res_line == $past(wr_addr, 2)));

endmodule

bind tag_cam tag_cam_chk #(.ENTRIES(ENTRIES), .KEY_W(KEY_W)) i_tag_cam_chk (.*);

// File: tb/test_tag_cam.sv
`timescale 1ns/1ps
module test_tag_cam;
  localparam int ENTRIES = 32;
  localparam int KEY_W   = 26;
  localparam int IDX_W   = $clog2(ENTRIES);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             lk_valid = 1'b0;
  logic [KEY_W-1:0] lk_key = '0;
  logic             wr_en = 1'b0;
  logic [IDX_W-1:0] wr_addr = '0;
  logic [KEY_W-1:0] wr_key = '0;
  logic             wr_valid = 1'b0;
  logic             res_valid, res_hit;
  logic [IDX_W-1:0] res_line;

  int checks = 0;
  int errors = 0;

  logic             m_vld [ENTRIES];
  logic [KEY_W-1:0] m_key [ENTRIES];

  always #4 clk = ~clk;

  tag_cam #(.ENTRIES(ENTRIES), .KEY_W(KEY_W)) i_tag_cam (.*);

  function automatic logic model_hit(input logic [KEY_W-1:0] k);
    for (int e = 0; e < ENTRIES; e++) if (m_vld[e] && m_key[e] == k) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [IDX_W-1:0] model_line(input logic [KEY_W-1:0] k);
    for (int e = 0; e < ENTRIES; e++) if (m_vld[e] && m_key[e] == k) return IDX_W'(e);
    return '0;
  endfunction

  task automatic expect_out(input string req, input logic v, input logic h,
                            input logic [IDX_W-1:0] l);
    checks++;
    if (res_valid !== v || res_hit !== h || res_line !== l) begin
      errors++;
      $display("FAIL %s: got valid=%0b hit=%0b line=%0d, expected valid=%0b hit=%0b line=%0d",
               req, res_valid, res_hit, res_line, v, h, l);
    end
  endtask

  // Called at a falling edge; drives one cycle and checks its result at the next falling edge.
  task automatic step(input string req, input logic lv, input logic [KEY_W-1:0] lk,
                      input logic we, input logic [IDX_W-1:0] wa,
                      input logic [KEY_W-1:0] wk, input logic wv);
    logic eh;
    logic [IDX_W-1:0] el;
    lk_valid = lv; lk_key = lk; wr_en = we; wr_addr = wa; wr_key = wk; wr_valid = wv;
    eh = lv && model_hit(lk);
    el = eh ? model_line(lk) : '0;
    @(posedge clk);
    if (we) begin m_vld[wa] = wv; m_key[wa] = wk; end
    @(negedge clk);
    expect_out(req, lv, eh, el);
  endtask

  function automatic logic [KEY_W-1:0] rkey();
    return KEY_W'(26'h2A5_0000 | ($urandom % 12));
  endfunction

  localparam logic [KEY_W-1:0] KA = 26'h1234567;
  localparam logic [KEY_W-1:0] KB = 26'h0ABCDEF;

  initial begin
    void'($urandom(32'd2718));
    for (int e = 0; e < ENTRIES; e++) begin m_vld[e] = 1'b0; m_key[e] = '0; end
    repeat (2) @(negedge clk);
    expect_out("R1 during reset", 1'b0, 1'b0, '0);
    rst_n = 1'b1;
    @(negedge clk);
    expect_out("R1 after release", 1'b0, 1'b0, '0);
    step("R1 R4 empty store", 1'b1, KA, 1'b0, '0, '0, 1'b0);

    step("R7 load", 1'b0, '0, 1'b1, 5'd5, KA, 1'b1);
    step("R3 R7 hit entry 5", 1'b1, KA, 1'b0, '0, '0, 1'b0);
    step("R7 load dup", 1'b0, '0, 1'b1, 5'd2, KA, 1'b1);
    step("R6 lowest of 2,5", 1'b1, KA, 1'b0, '0, '0, 1'b0);
    step("R8 invalidate 2", 1'b0, '0, 1'b1, 5'd2, KA, 1'b0);
    step("R8 R5 back to 5", 1'b1, KA, 1'b0, '0, '0, 1'b0);
    step("R9 same-cycle write", 1'b1, KA, 1'b1, 5'd0, KA, 1'b1);
    step("R9 R6 now entry 0", 1'b1, KA, 1'b0, '0, '0, 1'b0);
    step("R2 R10 idle", 1'b0, KA, 1'b0, '0, '0, 1'b0);
    step("R9 same-cycle invalidate", 1'b1, KA, 1'b1, 5'd0, KA, 1'b0);
    step("R8 entry 0 gone", 1'b1, KA, 1'b0, '0, '0, 1'b0);
    step("R4 miss", 1'b1, KB, 1'b0, '0, '0, 1'b0);
    step("R7 load 31", 1'b0, '0, 1'b1, 5'd31, KB, 1'b1);
    step("R3 top entry", 1'b1, KB, 1'b0, '0, '0, 1'b0);
    step("R8 drop 31", 1'b0, '0, 1'b1, 5'd31, KB, 1'b0);
    step("R5 stale key", 1'b1, KB, 1'b0, '0, '0, 1'b0);

    for (int i = 0; i < 3000; i++) begin
      step("R3 R4 R6 R9 random", 1'($urandom % 4 != 0), rkey(),
           1'($urandom % 2), IDX_W'($urandom), rkey(), 1'($urandom % 4 != 0));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule